// File: doc/BRIEF.md
# Four-Buffer Circular Trace Writer

This block takes a stream of trace-record words (32-bit DWs, each marked with an end-of-record flag) and stores them in memory through a simple write-request port that carries an address, data, a valid and a ready. Software programs four base addresses and one shared buffer size in DWs. The writer fills buffer 0 first, then 1, 2 and 3, and starts again at buffer 0 for as long as tracing stays enabled. Each DW goes to the active base plus four bytes times its word offset inside that buffer.

When memory accepts the final DW of a buffer, the block raises a one-cycle done pulse and gives the index of that buffer. Software acknowledges each finished buffer with a per-buffer ack bit. The writer keeps one pending flag per buffer. If it moves onto a buffer whose earlier done has not yet been acknowledged, it raises a sticky overrun flag. When the enable is cleared, the record in progress is finished before intake stops. While the writer is idle and disabled, its pointer rests at buffer 0, offset 0. A status pair always shows the buffer index and word offset where the next DW will be placed.

Top module: `trace_ring_writer`

## Requirements
- R1: Under reset, and on the first cycle after it, `mem_wr_valid`, `buf_done` and `overrun` are 0, `stat_idx` and `stat_off` are 0, and `in_ready` is 0 while `enable` is low.
- R2: A DW accepted at offset k of buffer i is issued with `mem_wr_addr` equal to base i plus 4·k, modulo 2^ADDR_W. Base i is `bases[i*ADDR_W +: ADDR_W]`. DWs are issued in the order they were accepted, with the data unchanged.
- R3: Buffers fill in the order 0, 1, 2, 3, 0, … . After `buf_size_dw` accepted DWs (a size of 0 counts as 1), the status moves to offset 0 of the next buffer. The status always names the slot the next DW will use.
- R4: The block has a single output register. While `mem_wr_valid` is high and `mem_wr_ready` is low, the address and data stay unchanged, and a new DW is accepted only when that register is empty or is being emptied in the same cycle.
- R5: In the cycle after memory accepts the final DW of a buffer, `buf_done` is high for one cycle and `buf_done_idx` gives that buffer's index. At no other time is `buf_done` high.
- R6: If `enable` goes low in the middle of a record, `in_ready` stays available until the DW marked `in_last` has been accepted, and then drops. While the block is idle with `enable` low, the status reads buffer 0, offset 0, and `overrun` is cleared.
- R7: A done event sets that buffer's pending flag. A high `done_ack[i]` clears pending flag i, but a done event for buffer i in the same cycle wins. Moving onto a buffer whose pending flag is set raises `overrun` in the next cycle. `overrun` then stays high until the writer is idle with `enable` low.
- R8: With a buffer size of one DW, every accepted DW ends a buffer. Each one produces its own done pulse, and the status offset stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Trace enable |
| bases | input | NUM_BUF*ADDR_W | Packed byte base addresses of the four buffers; buffer i sits at bits i*ADDR_W and up |
| buf_size_dw | input | SIZE_W | Shared buffer size in DWs (default width allows 4 MiB) |
| in_valid | input | 1 | Record DW available |
| in_data | input | DATA_W | Record DW |
| in_last | input | 1 | Marks the final DW of a record |
| in_ready | output | 1 | DW accepted when high together with in_valid |
| mem_wr_valid | output | 1 | Write request valid |
| mem_wr_addr | output | ADDR_W | Write byte address |
| mem_wr_data | output | DATA_W | Write data |
| mem_wr_ready | input | 1 | Memory accepts the write |
| done_ack | input | NUM_BUF | Per-buffer acknowledge of a done event |
| buf_done | output | 1 | One-cycle pulse: a buffer has been completely written |
| buf_done_idx | output | IDX_W | Index of the buffer that finished |
| overrun | output | 1 | Sticky: the writer moved onto an unacknowledged buffer |
| stat_idx | output | IDX_W | Buffer that the next DW will go to |
| stat_off | output | SIZE_W | DW offset that the next DW will use |

## Verification
The bench first runs a gap-free source into memory that is always ready, with no acknowledgements. Records of three DWs are written into five-DW buffers, so records straddle buffer boundaries, and the first wrap to buffer 0 must raise the overrun flag. Clearing the enable partway through a record shows whether intake ends exactly at the record's last DW and whether the pointer and flag return to their rest values. A run with sparse source traffic, random memory back-pressure and prompt acknowledgements tells the hold and address arithmetic apart from the wrap order, and it must finish with no overrun. A final run with one-DW buffers makes every word a buffer end and wrap, which checks the done pulses fired back to back.

// File: rtl/trw_pkg.sv
package trw_pkg;

  // Byte address of a DW: base plus four bytes per word of offset.
  function automatic logic [63:0] dw_byte_addr(input logic [63:0] base,
                                               input logic [63:0] dw_off);
    return base + (dw_off << 2);
  endfunction

  // True when the word at offset off is the final one of a buffer of size words.
  // A size of zero is treated as one word.
  function automatic logic is_buf_end(input logic [31:0] off,
                                      input logic [31:0] size);
    return (off + 32'd1) >= size;
  endfunction

  // Next slot in the ring of n buffers.
  function automatic int next_slot(input int idx, input int n);
    return (idx >= n - 1) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/trw_ptr.sv
module trw_ptr #(
  parameter int NUM_BUF = 4,
  parameter int IDX_W   = 2,
  parameter int SIZE_W  = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              step,
  input  logic [SIZE_W-1:0] size,
  output logic [IDX_W-1:0]  idx,
  output logic [SIZE_W-1:0] off,
  output logic              at_end,
  output logic [IDX_W-1:0]  nxt_idx
);

  assign at_end  = trw_pkg::is_buf_end(32'(off), 32'(size));
  assign nxt_idx = IDX_W'(trw_pkg::next_slot(int'(idx), NUM_BUF));

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      idx <= '0;
      off <= '0;
    end else if (step) begin
      if (at_end) begin
        off <= '0;
        idx <= nxt_idx;
      end else begin
        off <= off + SIZE_W'(1);
      end
    end
  end

endmodule

// File: rtl/trw_outreg.sv
module trw_outreg #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              ld_end,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic              ready,
  output logic              valid,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data,
  output logic              end_flag,
  output logic [IDX_W-1:0]  end_idx,
  output logic              fire
);

  assign fire = valid && ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid    <= 1'b0;
      addr     <= '0;
      data     <= '0;
      end_flag <= 1'b0;
      end_idx  <= '0;
    end else if (load) begin
      valid    <= 1'b1;
      addr     <= ld_addr;
      data     <= ld_data;
      end_flag <= ld_end;
      end_idx  <= ld_idx;
    end else if (fire) begin
      valid <= 1'b0;
    end
  end

endmodule

// File: rtl/trw_done.sv
module trw_done #(
  parameter int NUM_BUF = 4,
  parameter int IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               fin_evt,
  input  logic [IDX_W-1:0]   fin_idx,
  input  logic [NUM_BUF-1:0] ack,
  input  logic               wrap_evt,
  input  logic [IDX_W-1:0]   wrap_to,
  output logic               done,
  output logic [IDX_W-1:0]   done_idx,
  output logic               overrun,
  output logic [NUM_BUF-1:0] pending
);

  logic hit_pending;
  assign hit_pending = wrap_evt && pending[wrap_to];

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_pend
    always_ff @(posedge clk) begin
      if (!rst_n)
        pending[g] <= 1'b0;
      else if (fin_evt && (fin_idx == IDX_W'(g)))
        pending[g] <= 1'b1;
      else if (ack[g])
        pending[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done     <= 1'b0;
      done_idx <= '0;
      overrun  <= 1'b0;
    end else begin
      done <= fin_evt;
      if (fin_evt) done_idx <= fin_idx;
      if (restart)          overrun <= 1'b0;
      else if (hit_pending) overrun <= 1'b1;
    end
  end

endmodule

// File: rtl/trace_ring_writer.sv
module trace_ring_writer #(
  parameter int NUM_BUF = 4,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int SIZE_W  = 21,
  localparam int IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      enable,
  input  logic [NUM_BUF*ADDR_W-1:0] bases,
  input  logic [SIZE_W-1:0]         buf_size_dw,
  input  logic                      in_valid,
  input  logic [DATA_W-1:0]         in_data,
  input  logic                      in_last,
  output logic                      in_ready,
  output logic                      mem_wr_valid,
  output logic [ADDR_W-1:0]         mem_wr_addr,
  output logic [DATA_W-1:0]         mem_wr_data,
  input  logic                      mem_wr_ready,
  input  logic [NUM_BUF-1:0]        done_ack,
  output logic                      buf_done,
  output logic [IDX_W-1:0]          buf_done_idx,
  output logic                      overrun,
  output logic [IDX_W-1:0]          stat_idx,
  output logic [SIZE_W-1:0]         stat_off
);

  // Named internal events, brought out for the checker.
  logic              accept;
  logic              wrap_evt;
  logic              restart;
  logic              fire;
  logic              fin_evt;
  logic              in_rec;
  logic              at_end;
  logic [IDX_W-1:0]  nxt_idx;
  logic [ADDR_W-1:0] base_sel;
  logic [63:0]       addr64;
  logic              oreg_end;
  logic [IDX_W-1:0]  oreg_idx;
  logic [NUM_BUF-1:0] pending;

  assign restart  = !enable && !in_rec;
  assign in_ready = (enable || in_rec) && (!mem_wr_valid || mem_wr_ready);
  assign accept   = in_valid && in_ready;
  assign wrap_evt = accept && at_end;
  assign fin_evt  = fire && oreg_end;
  assign base_sel = bases[stat_idx*ADDR_W +: ADDR_W];
  assign addr64   = trw_pkg::dw_byte_addr(64'(base_sel), 64'(stat_off));

  always_ff @(posedge clk) begin
    if (!rst_n)      in_rec <= 1'b0;
    else if (accept) in_rec <= !in_last;
  end

  trw_ptr #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W), .SIZE_W(SIZE_W)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .step    (accept),
    .size    (buf_size_dw),
    .idx     (stat_idx),
    .off     (stat_off),
    .at_end  (at_end),
    .nxt_idx (nxt_idx)
  );

  trw_outreg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_oreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .ld_addr  (addr64[ADDR_W-1:0]),
    .ld_data  (in_data),
    .ld_end   (at_end),
    .ld_idx   (stat_idx),
    .ready    (mem_wr_ready),
    .valid    (mem_wr_valid),
    .addr     (mem_wr_addr),
    .data     (mem_wr_data),
    .end_flag (oreg_end),
    .end_idx  (oreg_idx),
    .fire     (fire)
  );

  trw_done #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) u_done (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .fin_evt  (fin_evt),
    .fin_idx  (oreg_idx),
    .ack      (done_ack),
    .wrap_evt (wrap_evt),
    .wrap_to  (nxt_idx),
    .done     (buf_done),
    .done_idx (buf_done_idx),
    .overrun  (overrun),
    .pending  (pending)
  );

endmodule

// File: rtl/trw_checker.sv
module trw_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic [SIZE_W-1:0] buf_size_dw,
  input logic              in_valid,
  input logic              in_last,
  input logic              in_ready,
  input logic              mem_wr_valid,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [DATA_W-1:0] mem_wr_data,
  input logic              mem_wr_ready,
  input logic              buf_done,
  input logic              overrun,
  input logic [SIZE_W-1:0] stat_off,
  input logic              wrap_evt
);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=>
      (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  assert_done_follows_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    buf_done |-> $past(mem_wr_valid && mem_wr_ready));

  assert_off_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_size_dw != '0 && $stable(buf_size_dw)) |-> (stat_off < buf_size_dw));

  assert_wrap_zero_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (stat_off == '0));

  assert_stop_at_record_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && in_valid && in_ready && in_last) |=> (enable || !in_ready));

  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && enable) |=> overrun);

endmodule

bind trace_ring_writer trw_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)
) u_trw_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .enable       (enable),
  .buf_size_dw  (buf_size_dw),
  .in_valid     (in_valid),
  .in_last      (in_last),
  .in_ready     (in_ready),
  .mem_wr_valid (mem_wr_valid),
  .mem_wr_addr  (mem_wr_addr),
  .mem_wr_data  (mem_wr_data),
  .mem_wr_ready (mem_wr_ready),
  .buf_done     (buf_done),
  .overrun      (overrun),
  .stat_off     (stat_off),
  .wrap_evt     (wrap_evt)
);

// File: tb/tb_trace_ring_writer.sv
module tb_trace_ring_writer;

  localparam int NB = 4;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int SW = 21;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic [NB*AW-1:0] bases;
  logic [SW-1:0] buf_size_dw = SW'(5);
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_last = 1'b0;
  logic          in_ready;
  logic          mem_wr_valid;
  logic [AW-1:0] mem_wr_addr;
  logic [DW-1:0] mem_wr_data;
  logic          mem_wr_ready = 1'b0;
  logic [NB-1:0] done_ack = '0;
  logic          buf_done;
  logic [1:0]    buf_done_idx;
  logic          overrun;
  logic [1:0]    stat_idx;
  logic [SW-1:0] stat_off;

  always #2 clk = ~clk;

  trace_ring_writer dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .bases(bases),
    .buf_size_dw(buf_size_dw), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .mem_wr_valid(mem_wr_valid),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_wr_ready(mem_wr_ready), .done_ack(done_ack), .buf_done(buf_done),
    .buf_done_idx(buf_done_idx), .overrun(overrun), .stat_idx(stat_idx),
    .stat_off(stat_off)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Controls, changed by the sequencer just after a rising edge.
  bit c_en = 0, c_ack = 0, c_ack_all = 0, c_rdy_rand = 0;
  int c_size = 5, c_len = 3, c_dens = 100;

  // Behavioural reference model.
  longint base_v [NB];
  int  m_idx, m_off, m_ovr, m_done, m_done_idx;
  bit  m_inrec, m_acc;
  bit  m_pend [NB];
  bit  m_ovv, m_ov_end;
  longint m_ov_addr, m_ov_data;
  int  m_ov_idx;
  int  src_pos;
  longint src_data;

  initial begin
    base_v[0] = 64'h0000_1000; base_v[1] = 64'h0040_0000;
    base_v[2] = 64'h8000_0100; base_v[3] = 64'hFFFF_FFF0;
    for (int i = 0; i < NB; i++) bases[i*AW +: AW] = base_v[i][AW-1:0];
  end

  function automatic bit exp_ready();
    return (enable || m_inrec) && (!m_ovv || mem_wr_ready);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_idx = 0; m_off = 0; m_ovr = 0; m_done = 0; m_done_idx = 0;
      m_inrec = 0; m_acc = 0; m_ovv = 0; m_ov_end = 0;
      m_ov_addr = 0; m_ov_data = 0; m_ov_idx = 0;
      for (int i = 0; i < NB; i++) m_pend[i] = 0;
    end else begin
      bit acc, fire, endw, was_rec;
      int sz, nxt;
      sz = (buf_size_dw == 0) ? 1 : int'(buf_size_dw);
      acc = in_valid && exp_ready();
      fire = m_ovv && mem_wr_ready;
      was_rec = m_inrec;
      endw = (m_off + 1 >= sz);
      nxt = (m_idx + 1) % NB;
      // done and pending
      for (int i = 0; i < NB; i++) if (done_ack[i]) m_pend[i] = 0;
      if (acc && endw && m_pend[nxt]) m_ovr = 1;
      m_done = fire && m_ov_end;
      if (m_done) begin m_done_idx = m_ov_idx; m_pend[m_ov_idx] = 1; end
      if (acc) begin
        m_ovv = 1;
        m_ov_addr = (base_v[m_idx] + 4 * m_off) & 64'hFFFF_FFFF;
        m_ov_data = in_data;
        m_ov_end = endw;
        m_ov_idx = m_idx;
        m_inrec = !in_last;
        if (endw) begin m_off = 0; m_idx = nxt; end
        else m_off = m_off + 1;
      end else if (fire) m_ovv = 0;
      if (!enable && !was_rec) begin m_idx = 0; m_off = 0; m_ovr = 0; end
      m_acc = acc;
    end
  end

  // Driver and per-cycle comparison, away from the rising edge.
  initial begin
    src_pos = 0; src_data = 64'hA000_0000;
    forever begin
      @(negedge clk);
      enable = c_en;
      buf_size_dw = SW'(c_size);
      mem_wr_ready = c_rdy_rand ? ($urandom % 3 != 0) : 1'b1;
      done_ack = c_ack_all ? '1 : ((c_ack && m_done != 0) ? NB'(1 << m_done_idx) : '0);
      if (m_acc) begin
        src_data++;
        src_pos = (src_pos >= c_len - 1) ? 0 : src_pos + 1;
      end
      if (!(in_valid && !m_acc)) in_valid = ($urandom % 100) < c_dens;
      in_data = src_data[DW-1:0];
      in_last = (src_pos >= c_len - 1);
      #1;
      if (rst_n) begin
        chk("R6 in_ready", in_ready, exp_ready());
        chk("R4 mem_wr_valid", mem_wr_valid, m_ovv);
        if (m_ovv) begin
          chk("R2 mem_wr_addr", mem_wr_addr, m_ov_addr);
          chk("R2 mem_wr_data", mem_wr_data, m_ov_data & 64'hFFFF_FFFF);
        end
        chk("R5 buf_done", buf_done, m_done);
        if (m_done) chk("R5 buf_done_idx", buf_done_idx, m_done_idx);
        chk("R7 overrun", overrun, m_ovr);
        chk("R3 stat_idx", stat_idx, m_idx);
        chk("R3 stat_off", stat_off, m_off);
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: state during and right after reset
    chk("R1 mem_wr_valid", mem_wr_valid, 0);
    chk("R1 buf_done", buf_done, 0);
    chk("R1 overrun", overrun, 0);
    rst_n = 1'b1;
    wait_cyc(1);
    chk("R1 stat_idx", stat_idx, 0);
    chk("R1 stat_off", stat_off, 0);
    chk("R1 in_ready", in_ready, 0);

    // Phase A: full rate, no acks, wrap onto unacknowledged buffer 0.
    c_size = 5; c_len = 3; c_dens = 100; c_rdy_rand = 0; c_en = 1;
    wait_cyc(40);
    chk("R7 overrun after unacked wrap", overrun, 1);

    // Phase B: stop mid-record.
    c_en = 0;
    wait_cyc(12);
    chk("R6 idle stat_idx", stat_idx, 0);
    chk("R6 idle stat_off", stat_off, 0);
    chk("R6 overrun cleared", overrun, 0);
    chk("R6 intake closed", in_ready, 0);

    // Clear all pending flags.
    c_ack_all = 1; wait_cyc(2); c_ack_all = 0;

    // Phase C: sparse source, back-pressure, prompt acks.
    c_size = 7; c_len = 4; c_dens = 60; c_rdy_rand = 1; c_ack = 1; c_en = 1;
    wait_cyc(600);
    chk("R7 no overrun with acks", overrun, 0);
    c_en = 0; wait_cyc(20);

    // Phase D: one-DW buffers.
    c_size = 1; c_len = 2; c_dens = 100; c_rdy_rand = 0; c_en = 1;
    wait_cyc(60);
    chk("R8 offset stays zero", stat_off, 0);
    c_en = 0; wait_cyc(10);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule